// File: doc/BRIEF.md
# Sleep and Wake Sequencer

This block runs on the always-on 32.768 kHz reference clock. It decides when the system PLL may run and when the system clock may be treated as usable. Software asks for sleep with a one-cycle command. The sequencer then takes the sequence down in order. It first withdraws the clock-valid indication, lets a short guard interval pass, and only then turns the PLL off. While the block sleeps, the reference clock keeps running, so the real-time counter elsewhere on that clock keeps time.

An interrupt ends sleep. The interrupt line is asynchronous and first passes through a flop chain. The sequencer then switches the PLL back on and counts a fixed number of reference ticks, about 1 ms, before it declares the system clock valid again.

The block has four states:
- `RUN`: PLL on, clock valid.
- `GATE_OFF`: PLL on, clock withdrawn, guard interval counting.
- `SLEEP`: PLL off.
- `SETTLE`: PLL on, lock interval counting.

It has these transitions:
- RUN→GATE_OFF on a sleep command.
- GATE_OFF→SLEEP when the guard count ends.
- GATE_OFF→SETTLE on a synchronised interrupt, which takes priority over the guard count.
- SLEEP→SETTLE on a synchronised interrupt.
- SETTLE→RUN when the lock count ends.

Top module: `sleep_wake_seq`

## Requirements
- R1: After reset the block is in RUN, with `pll_en` = 1 and `sysclk_valid` = 1.
- R2: A `sleep_req` sampled high in RUN drives `sysclk_valid` to 0 at that same clock edge, while `pll_en` stays 1.
- R3: `pll_en` falls exactly GATE_TICKS (default 2) edges after `sysclk_valid` falls, provided no interrupt arrives in between.
- R4: In SLEEP, `pll_en` and `sysclk_valid` both stay 0 for as long as no interrupt arrives.
- R5: `wake_irq` goes through a SYNC_STAGES-flop synchroniser (default 2). An interrupt raised before edge n is acted on at edge n+2, and SLEEP is left at that edge with `pll_en` returning to 1.
- R6: SETTLE lasts exactly SETTLE_TICKS edges (default 33), with `pll_en` = 1 and `sysclk_valid` = 0 throughout. `sysclk_valid` rises on the edge that follows the last settle tick.
- R7: A synchronised interrupt seen in GATE_OFF moves the block straight to SETTLE, and `pll_en` never drops.
- R8: `sleep_req` is ignored in GATE_OFF, SLEEP and SETTLE. It neither re-enters GATE_OFF nor changes the length of the settle interval.
- R9: `wake_irq` has no effect in RUN, so both outputs stay 1.
- R10: `sysclk_valid` is never 1 while `pll_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Always-on 32.768 kHz reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Sleep command, one cycle, synchronous to clk_ref |
| wake_irq | input | 1 | Asynchronous interrupt level that wakes the block |
| pll_en | output | 1 | Enable for the system PLL |
| sysclk_valid | output | 1 | System clock may be released to the core and peripherals |

## Verification
The bench builds the block with its default values: a 33-tick lock interval, a 2-tick guard interval and a 2-stage synchroniser. With these values, every tick of every interval can be measured exactly within a few hundred cycles. A table places the interrupt at offsets from the sleep command. The offsets cover the case where the interrupt arrives early enough to catch GATE_OFF, the exact boundary, and cases where it arrives well into SLEEP. For each offset the bench predicts the total wake time and whether the PLL is ever switched off.

// File: rtl/swseq_pkg.sv
package swseq_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_GATE_OFF = 2'd1,
        ST_SLEEP    = 2'd2,
        ST_SETTLE   = 2'd3
    } swseq_state_e;

endpackage

// File: rtl/swseq_sync.sv
module swseq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/swseq_tick_cnt.sv
module swseq_tick_cnt #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             done
);

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sleep_wake_seq.sv
module sleep_wake_seq
    import swseq_pkg::*;
#(
    parameter int unsigned SETTLE_TICKS = 33,
    parameter int unsigned GATE_TICKS   = 2,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic wake_irq,
    output logic pll_en,
    output logic sysclk_valid
);

    localparam int unsigned MAX_TICKS = (SETTLE_TICKS > GATE_TICKS) ? SETTLE_TICKS : GATE_TICKS;
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_TICKS - 1);
    localparam logic [CNT_W-1:0] GATE_LOAD   = CNT_W'(GATE_TICKS - 1);

    swseq_state_e     state_q, state_d;
    logic             irq_sync;
    logic             tick_done;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;

    swseq_sync #(.STAGES(SYNC_STAGES)) u_irq_sync (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .d_async (wake_irq),
        .q_sync  (irq_sync)
    );

    swseq_tick_cnt #(.WIDTH(CNT_W)) u_tick_cnt (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .done     (tick_done)
    );

    // Next-state and counter load decisions
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = GATE_LOAD;
        unique case (state_q)
            ST_RUN: begin
                if (sleep_req) begin
                    state_d  = ST_GATE_OFF;
                    cnt_load = 1'b1;
                    cnt_val  = GATE_LOAD;
                end
            end
            ST_GATE_OFF: begin
                if (irq_sync) begin
                    state_d  = ST_SETTLE;
                    cnt_load = 1'b1;
                    cnt_val  = SETTLE_LOAD;
                end else if (tick_done) begin
                    state_d  = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (irq_sync) begin
                    state_d  = ST_SETTLE;
                    cnt_load = 1'b1;
                    cnt_val  = SETTLE_LOAD;
                end
            end
            ST_SETTLE: begin
                if (tick_done) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        pll_en       = 1'b1;
        sysclk_valid = 1'b0;
        unique case (state_q)
            ST_RUN:      sysclk_valid = 1'b1;
            ST_GATE_OFF: pll_en       = 1'b1;
            ST_SLEEP:    pll_en       = 1'b0;
            ST_SETTLE:   pll_en       = 1'b1;
            default:     pll_en       = 1'b1;
        endcase
    end

    assert_valid_needs_pll_R10: assert property (@(posedge clk_ref) disable iff (!rst_n)
        sysclk_valid |-> pll_en);

    assert_req_drops_valid_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state_q == ST_RUN && sleep_req) |=> (!sysclk_valid && pll_en));

    assert_pll_off_after_gate_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(pll_en) |-> (!sysclk_valid && !$past(sysclk_valid)));

    assert_wake_from_sleep_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state_q == ST_SLEEP && irq_sync) |=> (pll_en && !sysclk_valid));

    assert_valid_after_settle_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(sysclk_valid) |-> ($past(state_q) == ST_SETTLE));

    assert_gate_only_from_run_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state_q != ST_RUN && state_q != ST_GATE_OFF) |=> (state_q != ST_GATE_OFF));

    assert_run_ignores_irq_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state_q == ST_RUN && !sleep_req) |=> (pll_en && sysclk_valid));

endmodule

// File: tb/sleep_wake_seq_tb.sv
`timescale 1ns/1ps
module sleep_wake_seq_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic wake_irq = 1'b0;
    logic pll_en, sysclk_valid;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    sleep_wake_seq u_dut (
        .clk_ref      (clk),
        .rst_n        (rst_n),
        .sleep_req    (sleep_req),
        .wake_irq     (wake_irq),
        .pll_en       (pll_en),
        .sysclk_valid (sysclk_valid)
    );

    // Interrupt raised at negedge IRQ_AT; sleep command at negedge 2.
    // Wake time counted in edges from the edge that takes the command.
    localparam int VEC_N = 6;
    localparam int VEC_IRQ_AT [VEC_N] = '{1, 2, 3, 4, 10, 40};
    localparam int VEC_WAKE   [VEC_N] = '{34, 35, 36, 37, 43, 73};
    localparam bit VEC_DROP   [VEC_N] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_vector(input int irq_at, input int exp_wake, input bit exp_drop);
        int  wake = -1;
        bit  dropped = 1'b0;
        wake_irq  = 1'b0;
        sleep_req = 1'b0;
        for (int i = 0; i < 400 && wake < 0; i++) begin
            @(negedge clk);
            if (i == irq_at) wake_irq = 1'b1;
            sleep_req = (i == 2);
            if (i >= 3) begin
                if (!pll_en) dropped = 1'b1;
                if (sysclk_valid) wake = i - 3;
            end
        end
        check(wake == exp_wake, "R5/R6 wake latency", wake, exp_wake);
        check(dropped == exp_drop, "R3/R7 pll dropped", int'(dropped), int'(exp_drop));
        wake_irq = 1'b0;
        idle(5);
    endtask

    initial begin
        idle(3);
        check(pll_en == 1'b1 && sysclk_valid == 1'b1, "R1 reset outputs",
              {pll_en, sysclk_valid}, 3);
        rst_n = 1'b1;
        idle(2);
        check(pll_en && sysclk_valid, "R1 after release", {pll_en, sysclk_valid}, 3);

        // R9: interrupt in RUN has no effect
        wake_irq = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(pll_en && sysclk_valid, "R9 irq in RUN", {pll_en, sysclk_valid}, 3);
        end
        wake_irq = 1'b0;
        idle(4);

        // Table-driven interrupt offsets
        for (int v = 0; v < VEC_N; v++)
            run_vector(VEC_IRQ_AT[v], VEC_WAKE[v], VEC_DROP[v]);

        // R2, R3: shutdown order
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        check(!sysclk_valid && pll_en, "R2 valid off first", {pll_en, sysclk_valid}, 2);
        @(negedge clk);
        check(!sysclk_valid && pll_en, "R3 guard tick", {pll_en, sysclk_valid}, 2);
        @(negedge clk);
        check(!sysclk_valid && !pll_en, "R3 pll off", {pll_en, sysclk_valid}, 0);

        // R4: stays asleep
        idle(60);
        check(!sysclk_valid && !pll_en, "R4 held asleep", {pll_en, sysclk_valid}, 0);

        // R8: request in SLEEP ignored
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        idle(3);
        check(!sysclk_valid && !pll_en, "R8 req in SLEEP", {pll_en, sysclk_valid}, 0);

        // R5, R6, R8: wake with a request inside SETTLE
        @(negedge clk); wake_irq = 1'b1;
        @(negedge clk);
        check(!pll_en, "R5 sync stage 1", pll_en, 0);
        @(negedge clk);
        check(!pll_en, "R5 sync stage 2", pll_en, 0);
        @(negedge clk);
        check(pll_en && !sysclk_valid, "R5 pll back on", {pll_en, sysclk_valid}, 2);
        for (int k = 4; k <= 35; k++) begin
            @(negedge clk);
            sleep_req = (k == 10);
            if (k == 35)
                check(pll_en && !sysclk_valid, "R6/R8 last settle tick", {pll_en, sysclk_valid}, 2);
        end
        sleep_req = 1'b0;
        @(negedge clk);
        check(pll_en && sysclk_valid, "R6 valid released", {pll_en, sysclk_valid}, 3);
        wake_irq = 1'b0;
        idle(4);

        // R1: reset in the middle of sleep
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        idle(5);
        rst_n = 1'b0;
        @(negedge clk);
        check(pll_en && sysclk_valid, "R1 reset from SLEEP", {pll_en, sysclk_valid}, 3);
        rst_n = 1'b1;
        idle(3);

        finished = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !finished; c++) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule